// File: doc/BRIEF.md
# Serial and Byte Loaded Converter Input Port

This block is the digital loading front end of an 18-bit converter. A code reaches it in one of two ways. It can arrive as a serial bit stream clocked by a slow serial clock. It can also arrive as two 8-bit halves written through separate high-half and low-half write enables. The assembled code waits in an input stage. A transfer strobe copies it into the output code register that drives the converter core. Because of this split, several converters on a shared bus can be filled one after another and then updated together.

The serial shift chain runs through the block to a serial output, so converters can be daisy chained on a single data line. The serial word length is 18 or 16 bits. The bit order is MSB first or LSB first. A 16-bit code, whether it comes in serially or as two halves, lands in the upper bits of the output code with zeros below it. An asynchronous active-low clear forces the output code to zero (most negative, offset binary) or to midscale, as picked by a select input. Reset loads the same clear value.

Top module: `dac_load_port`

## Requirements
- R1: While reset is asserted, `dac_code` holds the clear value picked by `clr_mid` (0 when low, 0x20000 when high) and `sout` is 0.
- R2: With `mode_byte`=0, `word_long`=1 and `lsb_first`=0, the first of 18 serial bits is bit 17 of the code, and a `ldac` strobe puts that code on `dac_code`.
- R3: With `lsb_first`=1, the first serial bit is bit 0 of the word, for both word lengths.
- R4: With `word_long`=0, the last 16 serial bits form a 16-bit word that appears on `dac_code[17:2]`, and `dac_code[1:0]` is 0.
- R5: With `mode_byte`=1, `hi_we` stores `byte_in` as `dac_code[17:10]` and `lo_we` stores it as `dac_code[9:2]`. The two halves may be written in either order, and `dac_code[1:0]` is 0 after the transfer.
- R6: Shifting serial bits or writing halves leaves `dac_code` unchanged until a clock edge with `ldac` high.
- R7: `sin` is taken on a rising `sclk` edge. After the following falling `sclk` edge, `sout` shows the bit in the last stage of the active word length. So the first bit shifted in appears on `sout` after 18 (or 16) `sclk` periods.
- R8: While `clr_n` is low, `dac_code` is 0 (`clr_mid`=0) or 0x20000 (`clr_mid`=1) without waiting for a clock, and `ldac` has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; `sclk` and the strobes are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_byte | input | 1 | 1: transfer takes the two stored halves; 0: transfer takes the serial word |
| word_long | input | 1 | Serial word length: 1 = 18 bits, 0 = 16 bits |
| lsb_first | input | 1 | Serial bit order: 1 = LSB first, 0 = MSB first |
| sclk | input | 1 | Serial clock, slower than `clk` |
| sin | input | 1 | Serial data in |
| sout | output | 1 | Serial data out to the next converter in a chain |
| byte_in | input | 8 | Half-word data bus |
| hi_we | input | 1 | Write `byte_in` into the high half |
| lo_we | input | 1 | Write `byte_in` into the low half |
| ldac | input | 1 | Transfer strobe, input stage to output code |
| clr_n | input | 1 | Asynchronous active-low clear of the output code |
| clr_mid | input | 1 | Clear value select: 1 = midscale, 0 = zero |
| dac_code | output | 18 | Output code to the converter core |

## Verification
The bench builds the block with its default widths: an 18-bit code, a 16-bit short word and 8-bit halves. With these widths it can see zero padding below a short word and the split of the code into two halves with two padding bits. It also covers both chain lengths on `sout` and the exact midscale bit 17. A table drives serial words in all four combinations of length and bit order. Directed tests then cover both half-write orders, the hold before transfer, chain output after 16 and 18 bits, and the clear in both selections with a strobe during clear.

// File: rtl/dac_load_pkg.sv
package dac_load_pkg;
  localparam int CODE_W_DEF  = 18;
  localparam int SHORT_W_DEF = 16;
  localparam int BYTE_W_DEF  = 8;

  function automatic logic [CODE_W_DEF-1:0] clear_code(input logic mid);
    logic [CODE_W_DEF-1:0] c;
    c = '0;
    c[CODE_W_DEF-1] = mid;
    return c;
  endfunction
endpackage

// File: rtl/dac_serial_shift.sv
module dac_serial_shift #(
  parameter int CODE_W  = 18,
  parameter int SHORT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              sin,
  input  logic              len_long,
  input  logic              lsb_first,
  output logic              sout,
  output logic [CODE_W-1:0] word
);
  localparam int PAD_W = CODE_W - SHORT_W;

  logic              sclk_q;
  logic [CODE_W-1:0] chain_q, chain_d;
  logic              sout_q, sout_d;
  logic              rise, fall, tail;
  logic [CODE_W-1:0]  rev_long;
  logic [SHORT_W-1:0] rev_short;

  assign rise = sclk & ~sclk_q;
  assign fall = ~sclk & sclk_q;
  assign tail = len_long ? chain_q[CODE_W-1] : chain_q[SHORT_W-1];

  for (genvar i = 0; i < CODE_W; i++) begin : g_rev_long
    assign rev_long[i] = chain_q[CODE_W-1-i];
  end
  for (genvar i = 0; i < SHORT_W; i++) begin : g_rev_short
    assign rev_short[i] = chain_q[SHORT_W-1-i];
  end

  always_comb begin
    chain_d = chain_q;
    sout_d  = sout_q;
    if (rise) chain_d = {chain_q[CODE_W-2:0], sin};
    if (fall) sout_d  = tail;
  end

  always_comb begin
    if (len_long) word = lsb_first ? rev_long : chain_q;
    else          word = {(lsb_first ? rev_short : chain_q[SHORT_W-1:0]), {PAD_W{1'b0}}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q  <= 1'b0;
      chain_q <= '0;
      sout_q  <= 1'b0;
    end else begin
      sclk_q  <= sclk;
      chain_q <= chain_d;
      sout_q  <= sout_d;
    end
  end

  assign sout = sout_q;
endmodule

// File: rtl/dac_byte_regs.sv
module dac_byte_regs #(
  parameter int BYTE_W = 8,
  parameter int CODE_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] byte_in,
  input  logic              hi_we,
  input  logic              lo_we,
  output logic [CODE_W-1:0] word
);
  localparam int PAD_W = CODE_W - 2 * BYTE_W;

  logic [BYTE_W-1:0] hi_q, hi_d, lo_q, lo_d;

  always_comb begin
    hi_d = hi_we ? byte_in : hi_q;
    lo_d = lo_we ? byte_in : lo_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else begin
      hi_q <= hi_d;
      lo_q <= lo_d;
    end
  end

  assign word = {hi_q, lo_q, {PAD_W{1'b0}}};
endmodule

// File: rtl/dac_output_latch.sv
module dac_output_latch #(
  parameter int CODE_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_n,
  input  logic              clr_mid,
  input  logic              load,
  input  logic [CODE_W-1:0] next_code,
  output logic [CODE_W-1:0] code
);
  logic [CODE_W-1:0] code_q, code_d, clr_val;

  always_comb begin
    clr_val = '0;
    clr_val[CODE_W-1] = clr_mid;
    code_d = load ? next_code : code_q;
  end

  always_ff @(posedge clk or negedge rst_n or negedge clr_n) begin
    if (!rst_n)      code_q <= clr_val;
    else if (!clr_n) code_q <= clr_val;
    else             code_q <= code_d;
  end

  assign code = code_q;
endmodule

// File: rtl/dac_load_port.sv
module dac_load_port
  import dac_load_pkg::*;
#(
  parameter int CODE_W  = CODE_W_DEF,
  parameter int SHORT_W = SHORT_W_DEF,
  parameter int BYTE_W  = BYTE_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_byte,
  input  logic              word_long,
  input  logic              lsb_first,
  input  logic              sclk,
  input  logic              sin,
  output logic              sout,
  input  logic [BYTE_W-1:0] byte_in,
  input  logic              hi_we,
  input  logic              lo_we,
  input  logic              ldac,
  input  logic              clr_n,
  input  logic              clr_mid,
  output logic [CODE_W-1:0] dac_code
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic [CODE_W-1:0] ser_word, byte_word, sel_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  dac_serial_shift #(.CODE_W(CODE_W), .SHORT_W(SHORT_W)) u_ser (
    .clk(clk), .rst_n(rst_int_n), .sclk(sclk), .sin(sin),
    .len_long(word_long), .lsb_first(lsb_first), .sout(sout), .word(ser_word)
  );

  dac_byte_regs #(.BYTE_W(BYTE_W), .CODE_W(CODE_W)) u_byte (
    .clk(clk), .rst_n(rst_int_n), .byte_in(byte_in),
    .hi_we(hi_we), .lo_we(lo_we), .word(byte_word)
  );

  assign sel_word = mode_byte ? byte_word : ser_word;

  dac_output_latch #(.CODE_W(CODE_W)) u_out (
    .clk(clk), .rst_n(rst_int_n), .clr_n(clr_n), .clr_mid(clr_mid),
    .load(ldac), .next_code(sel_word), .code(dac_code)
  );
endmodule

// File: rtl/dac_load_port_chk.sv
module dac_load_port_chk #(
  parameter int CODE_W  = 18,
  parameter int SHORT_W = 16,
  parameter int BYTE_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mode_byte,
  input logic              word_long,
  input logic              lsb_first,
  input logic              sclk,
  input logic              sin,
  input logic              sout,
  input logic [BYTE_W-1:0] byte_in,
  input logic              hi_we,
  input logic              lo_we,
  input logic              ldac,
  input logic              clr_n,
  input logic              clr_mid,
  input logic [CODE_W-1:0] dac_code
);
  localparam logic [CODE_W-1:0] MID = {1'b1, {(CODE_W-1){1'b0}}};

  a_r8_clear_value: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |-> dac_code == (clr_mid ? MID : '0));

  a_r6_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && !ldac) |=> (!clr_n || $stable(dac_code)));

  a_r4_short_word_padding: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && ldac && (mode_byte || !word_long)) |=>
      (!clr_n || dac_code[CODE_W-SHORT_W-1:0] == '0));

  a_r7_sout_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sout) |-> ($past(sclk) == 1'b0 && $past(sclk, 2) == 1'b1));
endmodule

bind dac_load_port dac_load_port_chk #(.CODE_W(CODE_W), .SHORT_W(SHORT_W), .BYTE_W(BYTE_W)) u_chk (.*);

// File: tb/sim_dac_load_port.sv
module sim_dac_load_port;
  logic        clk = 1'b0;
  logic        rst_n, mode_byte, word_long, lsb_first, sclk, sin;
  logic        hi_we, lo_we, ldac, clr_n, clr_mid;
  logic [7:0]  byte_in;
  logic        sout;
  logic [17:0] dac_code;
  int n_run = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  dac_load_port u0 (
    .clk(clk), .rst_n(rst_n), .mode_byte(mode_byte), .word_long(word_long),
    .lsb_first(lsb_first), .sclk(sclk), .sin(sin), .sout(sout),
    .byte_in(byte_in), .hi_we(hi_we), .lo_we(lo_we), .ldac(ldac),
    .clr_n(clr_n), .clr_mid(clr_mid), .dac_code(dac_code)
  );

  // {word_long, lsb_first, data[17:0], expected[17:0]}
  localparam logic [37:0] VEC [6] = '{
    {1'b1, 1'b0, 18'h2B6D1, 18'h2B6D1},   // R2
    {1'b1, 1'b1, 18'h15A3C, 18'h15A3C},   // R3
    {1'b0, 1'b0, 18'h0A5C3, 18'h2970C},   // R4
    {1'b0, 1'b1, 18'h01234, 18'h048D0},   // R4 R3
    {1'b1, 1'b0, 18'h3FFFF, 18'h3FFFF},   // R2
    {1'b1, 1'b1, 18'h00001, 18'h00001}    // R3
  };

  task automatic check(input string req, input logic [17:0] act, input logic [17:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sbit(input logic b);
    sin = b;
    repeat (2) @(negedge clk);
    sclk = 1'b1;
    repeat (2) @(negedge clk);
    sclk = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic sword(input logic [17:0] d, input int len, input logic lsb);
    for (int i = 0; i < len; i++) sbit(lsb ? d[i] : d[len-1-i]);
  endtask

  task automatic strobe();
    @(negedge clk); ldac = 1'b1;
    @(negedge clk); ldac = 1'b0;
    @(negedge clk);
  endtask

  task automatic wr_half(input logic hi, input logic [7:0] v);
    @(negedge clk); byte_in = v; hi_we = hi; lo_we = ~hi;
    @(negedge clk); hi_we = 1'b0; lo_we = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [17:0] prev;
    rst_n = 1'b0; mode_byte = 1'b0; word_long = 1'b1; lsb_first = 1'b0;
    sclk = 1'b0; sin = 1'b0; byte_in = '0; hi_we = 1'b0; lo_we = 1'b0;
    ldac = 1'b0; clr_n = 1'b1; clr_mid = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 reset code", dac_code, 18'h20000);
    check("R1 reset sout", {17'd0, sout}, 18'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    prev = 18'h20000;
    for (int k = 0; k < 6; k++) begin
      word_long = VEC[k][37];
      lsb_first = VEC[k][36];
      sword(VEC[k][35:18], word_long ? 18 : 16, lsb_first);
      check("R6 hold before strobe", dac_code, prev);
      strobe();
      check("R2 R3 R4 serial load", dac_code, VEC[k][17:0]);
      prev = VEC[k][17:0];
    end

    // R7 chain output, 18-bit
    word_long = 1'b1; lsb_first = 1'b0;
    sword(18'h2B6D1, 18, 1'b0);
    check("R7 sout after 18", {17'd0, sout}, 18'h1);
    sbit(1'b0);
    check("R7 sout after 19", {17'd0, sout}, 18'h0);
    sbit(1'b0);
    check("R7 sout after 20", {17'd0, sout}, 18'h1);
    // R7 chain output, 16-bit
    word_long = 1'b0;
    sword(18'h0A5C3, 16, 1'b0);
    check("R7 sout after 16", {17'd0, sout}, 18'h1);
    sbit(1'b1);
    check("R7 sout after 17", {17'd0, sout}, 18'h0);

    // R5 halves, low first then high
    mode_byte = 1'b1;
    prev = dac_code;
    wr_half(1'b0, 8'h5A);
    wr_half(1'b1, 8'hC3);
    check("R6 halves held", dac_code, prev);
    strobe();
    check("R5 low then high", dac_code, 18'h30D68);
    wr_half(1'b1, 8'h7E);
    wr_half(1'b0, 8'h81);
    strobe();
    check("R5 high then low", dac_code, 18'h1FA04);

    // R8 clear to midscale, strobe ignored
    clr_mid = 1'b1;
    @(negedge clk); #2 clr_n = 1'b0; #1;
    check("R8 async clear mid", dac_code, 18'h20000);
    strobe();
    check("R8 strobe during clear", dac_code, 18'h20000);
    clr_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R8 held after release", dac_code, 18'h20000);
    strobe();
    check("R5 reload after clear", dac_code, 18'h1FA04);
    clr_mid = 1'b0;
    @(negedge clk); #2 clr_n = 1'b0; #1;
    check("R8 async clear zero", dac_code, 18'h00000);
    @(negedge clk); clr_n = 1'b1;
    repeat (2) @(negedge clk);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule